// File: doc/BRIEF.md
# Hot-Insertion Bus Stall Controller

This block watches one backplane slot while a card is pushed in or pulled out. Each slot has three contact pins of different lengths. The longest pin touches first and the shortest pin touches last. Each pin is first synchronised to the clock and then filtered by a hold counter. A slot state machine then steps through the seating sequence. It stalls the shared bus while the card is only partly seated, so that transfers already on the bus are not corrupted. It turns on the slot's data path once the middle pin is made, and releases the stall once the short pin is made. Removal runs the same stages in reverse order.

The controller also checks how the card is inserted. If the short pin arrives before a minimum dwell time after the long pin, or arrives before the middle pin, the insertion counts as too fast. In that case the stall is kept and an error flag is raised until the card is fully withdrawn. A card that never finishes seating keeps the stall on, and so does one that is pushed in too slowly. A watchdog on the stall raises a sticky chassis reload request when the stall lasts too long. The filter length, the dwell time and the stall limit are all parameters.

Top module: `slot_seat_ctrl`

## Requirements
- R1: After reset, bus_stall_o, data_en_o, seated_o, err_fast_o and reload_req_o are all low and the slot is treated as empty.
- R2: A pin change is accepted only after the synchronised pin has differed from its filtered value for DEB_LEN consecutive clocks. Pulses shorter than that have no effect on any output.
- R3: When the filtered long pin is made on an empty slot, bus_stall_o goes high on the next clock and stays high until the card is seated or withdrawn.
- R4: When the filtered middle pin is made while the stall is on, data_en_o goes high and the stall stays on.
- R5: When the filtered short pin is made after the middle pin, and at least MIN_DWELL clocks have passed since the stall began, bus_stall_o goes low and seated_o goes high while data_en_o stays high.
- R6: If the short pin is made before MIN_DWELL clocks have passed, or while the middle pin is not yet made, the block holds the stall, clears data_en_o and raises err_fast_o. Both stay that way until all three filtered pins are open.
- R7: On removal from the seated state, loss of the short pin turns the stall on with data still enabled. Loss of the middle pin then disables data. Loss of the long pin then releases the stall.
- R8: Once bus_stall_o has been high for STALL_LIMIT consecutive clocks, reload_req_o goes high and stays high until reset.
- R9: A withdrawal during insertion backs out cleanly. Losing the middle pin before the short pin clears data_en_o and keeps the stall. Losing the long pin before the middle pin releases the stall, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_long_i | input | 1 | Raw contact detect of the longest pin |
| pin_mid_i | input | 1 | Raw contact detect of the middle pin |
| pin_short_i | input | 1 | Raw contact detect of the shortest pin |
| bus_stall_o | output | 1 | Stall request to the shared bus |
| data_en_o | output | 1 | Enables the slot's data connection |
| seated_o | output | 1 | Card fully seated, bus running |
| err_fast_o | output | 1 | Insertion too fast or out of order |
| reload_req_o | output | 1 | Sticky chassis reload request after an overlong stall |

## Verification
All outputs are decoded from the slot state. A wrong state therefore shows up at the ports on the clock right after the faulty transition, as a stall, data enable or error level that differs from what the pin history implies. A wrong dwell or stall count is harder to see: it only shows when the short pin is judged or when the stall limit is reached, which can be tens or hundreds of clocks later. For that reason the bench runs a behavioural model of the pin history every clock and compares all five outputs on every cycle, rather than only at scenario ends.

// File: rtl/seat_pkg.sv
package seat_pkg;
  localparam int unsigned NUM_PINS  = 3;
  localparam int unsigned PIN_LONG  = 0;
  localparam int unsigned PIN_MID   = 1;
  localparam int unsigned PIN_SHORT = 2;

  typedef enum logic [2:0] {
    SLOT_EMPTY  = 3'd0,
    SLOT_STALL  = 3'd1,
    SLOT_LINK   = 3'd2,
    SLOT_SEATED = 3'd3,
    SLOT_FAULT  = 3'd4,
    SLOT_DRAIN  = 3'd5,
    SLOT_UNLINK = 3'd6
  } seat_state_e;
endpackage

// File: rtl/contact_filter.sv
module contact_filter #(
  parameter int unsigned DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = $clog2(DEB_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clean_q, clean_d;

  always_comb begin
    clean_d = clean_q;
    cnt_d   = '0;
    if (sync_q[1] != clean_q) begin
      if (cnt_q == CW'(DEB_LEN - 1)) begin
        clean_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      clean_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      cnt_q   <= cnt_d;
      clean_q <= clean_d;
    end
  end

  assign clean_o = clean_q;

  AST_CHANGE_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q != $past(clean_q)) |-> ($past(sync_q[1]) != $past(clean_q))); // R2
  AST_NO_CHANGE_WHEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] == clean_q) |=> (clean_q == $past(clean_q))); // R2
endmodule

// File: rtl/seat_fsm.sv
module seat_fsm
  import seat_pkg::*;
#(
  parameter int unsigned MIN_DWELL = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_i,
  input  logic mid_i,
  input  logic short_i,
  output logic bus_stall_o,
  output logic data_en_o,
  output logic seated_o,
  output logic err_fast_o
);
  localparam int unsigned DW = $clog2(MIN_DWELL + 2);

  seat_state_e   state_q, state_d;
  logic [DW-1:0] dwell_q, dwell_d;
  logic          dwell_ok;

  assign dwell_ok = (dwell_q >= DW'(MIN_DWELL));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_EMPTY:  if (long_i) state_d = SLOT_STALL;
      SLOT_STALL: begin
        if (!long_i)      state_d = SLOT_EMPTY;
        else if (short_i) state_d = SLOT_FAULT;
        else if (mid_i)   state_d = SLOT_LINK;
      end
      SLOT_LINK: begin
        if (short_i)      state_d = dwell_ok ? SLOT_SEATED : SLOT_FAULT;
        else if (!mid_i)  state_d = SLOT_STALL;
      end
      SLOT_SEATED: if (!short_i) state_d = SLOT_DRAIN;
      SLOT_DRAIN: begin
        if (short_i)      state_d = SLOT_SEATED;
        else if (!mid_i)  state_d = SLOT_UNLINK;
      end
      SLOT_UNLINK: begin
        if (mid_i)        state_d = SLOT_DRAIN;
        else if (!long_i) state_d = SLOT_EMPTY;
      end
      SLOT_FAULT:  if (!long_i && !mid_i && !short_i) state_d = SLOT_EMPTY;
      default:     state_d = SLOT_EMPTY;
    endcase
  end

  always_comb begin
    dwell_d = '0;
    if (state_q == SLOT_STALL || state_q == SLOT_LINK) begin
      dwell_d = dwell_ok ? dwell_q : dwell_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
      dwell_q <= '0;
    end else begin
      state_q <= state_d;
      dwell_q <= dwell_d;
    end
  end

  assign bus_stall_o = (state_q == SLOT_STALL) || (state_q == SLOT_LINK) ||
                       (state_q == SLOT_FAULT) || (state_q == SLOT_DRAIN) ||
                       (state_q == SLOT_UNLINK);
  assign data_en_o   = (state_q == SLOT_LINK) || (state_q == SLOT_SEATED) ||
                       (state_q == SLOT_DRAIN);
  assign seated_o    = (state_q == SLOT_SEATED);
  assign err_fast_o  = (state_q == SLOT_FAULT);

  AST_STALL_ON_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_EMPTY && long_i) |=> bus_stall_o); // R3
  AST_RELEASE_AFTER_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(seated_o) && $past(state_q == SLOT_LINK)) |-> ($past(dwell_q) >= DW'(MIN_DWELL))); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fast_o && (long_i || mid_i || short_i)) |=> (err_fast_o && bus_stall_o)); // R6
  AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (seated_o && !short_i) |=> (bus_stall_o && data_en_o)); // R7
endmodule

// File: rtl/stall_watch.sv
module stall_watch #(
  parameter int unsigned STALL_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_i,
  output logic reload_o
);
  localparam int unsigned CW = $clog2(STALL_LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          reload_q, reload_d;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(STALL_LIMIT - 1));

  always_comb begin
    cnt_d    = '0;
    reload_d = reload_q;
    if (stall_i) begin
      cnt_d = at_limit ? cnt_q : cnt_q + 1'b1;
      if (at_limit) reload_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
    end
  end

  assign reload_o = reload_q;

  AST_RELOAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |=> reload_q); // R8
  AST_RELOAD_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_q) |-> $past(stall_i)); // R8
endmodule

// File: rtl/slot_seat_ctrl.sv
module slot_seat_ctrl
  import seat_pkg::*;
#(
  parameter int unsigned DEB_LEN     = 16,
  parameter int unsigned MIN_DWELL   = 1000,
  parameter int unsigned STALL_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_long_i,
  input  logic pin_mid_i,
  input  logic pin_short_i,
  output logic bus_stall_o,
  output logic data_en_o,
  output logic seated_o,
  output logic err_fast_o,
  output logic reload_req_o
);
  logic                rst_meta_q, rst_sync_q;
  logic [NUM_PINS-1:0] raw_pins, clean_pins;
  logic                stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign raw_pins[PIN_LONG]  = pin_long_i;
  assign raw_pins[PIN_MID]   = pin_mid_i;
  assign raw_pins[PIN_SHORT] = pin_short_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    contact_filter #(.DEB_LEN(DEB_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .raw_i  (raw_pins[g]),
      .clean_o(clean_pins[g])
    );
  end

  seat_fsm #(.MIN_DWELL(MIN_DWELL)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .long_i     (clean_pins[PIN_LONG]),
    .mid_i      (clean_pins[PIN_MID]),
    .short_i    (clean_pins[PIN_SHORT]),
    .bus_stall_o(stall),
    .data_en_o  (data_en_o),
    .seated_o   (seated_o),
    .err_fast_o (err_fast_o)
  );

  stall_watch #(.STALL_LIMIT(STALL_LIMIT)) u_watch (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .stall_i (stall),
    .reload_o(reload_req_o)
  );

  assign bus_stall_o = stall;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> !(bus_stall_o || data_en_o || reload_req_o)); // R1
endmodule

// File: tb/slot_seat_ctrl_test.sv
module slot_seat_ctrl_test;
  localparam int DEB = 4;
  localparam int DWELL = 20;
  localparam int LIMIT = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pl = 1'b0, pm = 1'b0, ps = 1'b0;
  logic stall, den, seat, errf, rld;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  slot_seat_ctrl #(.DEB_LEN(DEB), .MIN_DWELL(DWELL), .STALL_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .pin_long_i(pl), .pin_mid_i(pm), .pin_short_i(ps),
    .bus_stall_o(stall), .data_en_o(den), .seated_o(seat), .err_fast_o(errf),
    .reload_req_o(rld)
  );

  // behavioural reference: 0 empty,1 stall,2 link,3 seated,4 fault,5 drain,6 unlink
  int rel, st, dwell, scnt;
  bit m_rl;
  bit s1[3], s2[3], cl[3];
  int cnt[3];

  function automatic bit m_stall(int s);
    return s == 1 || s == 2 || s == 4 || s == 5 || s == 6;
  endfunction

  task automatic model_clear();
    st = 0; dwell = 0; scnt = 0; m_rl = 0;
    for (int i = 0; i < 3; i++) begin s1[i] = 0; s2[i] = 0; cl[i] = 0; cnt[i] = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; model_clear();
    end else if (rel < 2) begin
      rel++; model_clear();
    end else begin
      bit pins[3];
      int nst;
      bit old_stall;
      pins[0] = pl; pins[1] = pm; pins[2] = ps;
      old_stall = m_stall(st);
      nst = st;
      case (st)
        0: if (cl[0]) nst = 1;
        1: if (!cl[0]) nst = 0; else if (cl[2]) nst = 4; else if (cl[1]) nst = 2;
        2: if (cl[2]) nst = (dwell >= DWELL) ? 3 : 4; else if (!cl[1]) nst = 1;
        3: if (!cl[2]) nst = 5;
        5: if (cl[2]) nst = 3; else if (!cl[1]) nst = 6;
        6: if (cl[1]) nst = 5; else if (!cl[0]) nst = 0;
        4: if (!cl[0] && !cl[1] && !cl[2]) nst = 0;
        default: nst = 0;
      endcase
      if (st == 1 || st == 2) begin if (dwell < DWELL) dwell++; end else dwell = 0;
      if (old_stall) begin
        if (scnt >= LIMIT - 1) m_rl = 1; else scnt++;
      end else scnt = 0;
      st = nst;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] != cl[i]) begin
          if (cnt[i] == DEB - 1) begin cl[i] = s2[i]; cnt[i] = 0; end else cnt[i]++;
        end else cnt[i] = 0;
        s2[i] = s1[i]; s1[i] = pins[i];
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("R3 bus_stall", stall, m_stall(st));
    chk("R4 data_en", den, (st == 2 || st == 3 || st == 5));
    chk("R5 seated", seat, (st == 3));
    chk("R6 err_fast", errf, (st == 4));
    chk("R8 reload", rld, m_rl);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string tag, bit e_st, bit e_de, bit e_se, bit e_er, bit e_rl);
    chk(tag, stall, e_st); chk(tag, den, e_de); chk(tag, seat, e_se);
    chk(tag, errf, e_er); chk(tag, rld, e_rl);
  endtask

  initial begin
    wait_cyc(3);
    expect_out("R1 reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    expect_out("R1 after release", 0, 0, 0, 0, 0);

    // R2: short glitch on the long pin is ignored
    pl = 1; wait_cyc(2); pl = 0; wait_cyc(12);
    expect_out("R2 glitch", 0, 0, 0, 0, 0);

    // normal insertion
    pl = 1; wait_cyc(12);
    expect_out("R3 long made", 1, 0, 0, 0, 0);
    pm = 1; wait_cyc(30);
    expect_out("R4 mid made", 1, 1, 0, 0, 0);
    ps = 1; wait_cyc(12);
    expect_out("R5 seated", 0, 1, 1, 0, 0);

    // R7 removal order
    ps = 0; wait_cyc(12);
    expect_out("R7 short lost", 1, 1, 0, 0, 0);
    pm = 0; wait_cyc(12);
    expect_out("R7 mid lost", 1, 0, 0, 0, 0);
    pl = 0; wait_cyc(12);
    expect_out("R7 long lost", 0, 0, 0, 0, 0);

    // R6 too fast
    pl = 1; wait_cyc(8); pm = 1; wait_cyc(2); ps = 1; wait_cyc(12);
    expect_out("R6 too fast", 1, 0, 0, 1, 0);
    ps = 0; pm = 0; wait_cyc(12);
    expect_out("R6 held with long", 1, 0, 0, 1, 0);
    pl = 0; wait_cyc(12);
    expect_out("R6 cleared", 0, 0, 0, 0, 0);

    // R6 short before middle
    pl = 1; wait_cyc(12); ps = 1; wait_cyc(12);
    expect_out("R6 skipped mid", 1, 0, 0, 1, 0);
    pl = 0; ps = 0; wait_cyc(12);
    expect_out("R6 skipped mid cleared", 0, 0, 0, 0, 0);

    // R9 back-outs
    pl = 1; wait_cyc(12); pm = 1; wait_cyc(12);
    pm = 0; wait_cyc(12);
    expect_out("R9 mid withdrawn", 1, 0, 0, 0, 0);
    pl = 0; wait_cyc(12);
    expect_out("R9 long withdrawn", 0, 0, 0, 0, 0);

    // R8 incomplete insertion runs out the stall limit
    pl = 1; pm = 1; wait_cyc(LIMIT + 40);
    expect_out("R8 reload raised", 1, 1, 0, 0, 1);
    pl = 0; pm = 0; wait_cyc(20);
    expect_out("R8 reload sticky", 0, 0, 0, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: got running expected done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule